// File: doc/BRIEF.md
# Programmable Edge Delay Core

The core reproduces a one-bit logic level at its output, without inversion, a programmed number of system clock cycles after the level is sampled at its input. The delay is a fixed base offset plus an 8-bit setting times a step size. Both offsets are given in clock cycles. Rising and falling transitions are delayed by the same amount. A setting of zero still gives the base delay.

The core relies on two conditions on the input. Every high or low phase must last at least as long as the programmed delay. The period must be at least twice that phase width. Under these conditions only one transition can be waiting for its release time, so the core keeps a single pending-edge slot instead of a deep shift line. If a transition arrives while another is still waiting, the core raises a sticky `overrun` flag. The newer transition then takes the place of the older one. Writing a new setting drops `settled` for a fixed number of cycles.

All pins are plain level or strobe signals. There is no valid/ready handshake and no back-pressure. The input is sampled on every clock edge, and the output never stalls.

Top module: `edge_delay_core`

## Requirements
- R1: While reset is asserted and after it is released, `sig_out` is 0, `settled` is 1 and `overrun` is 0, and no transition is pending. The active setting is 0.
- R2: A transition of `sig_in` sampled at clock edge k appears on `sig_out`, with the same level and no inversion, at clock edge k+D.
- R3: D = BASE_CYCLES + value × STEP_CYCLES, where value is the active 8-bit setting. Value 0 gives BASE_CYCLES, and value 255 gives the largest delay.
- R4: Rising and falling transitions get the same delay D.
- R5: A setting applied by `cfg_load` high at edge k is used only for transitions sampled after edge k. A transition sampled at edge k or earlier keeps the delay that was active when it was sampled.
- R6: `cfg_load` high at edge k drives `settled` low from edge k. `settled` returns high at edge k+SETTLE_CYCLES.
- R7: A `cfg_load` while `settled` is low restarts the full SETTLE_CYCLES window from that load.
- R8: A transition sampled while an earlier one is pending, and that earlier one is not being released at the same edge, sets `overrun`. `overrun` stays 1 until reset. The earlier transition is discarded, so a pulse shorter than D never appears on `sig_out`.
- R9: A transition sampled at the same edge where the pending one is released is accepted without setting `overrun`. Both transitions appear on `sig_out`.
- R10: `cfg_value` has no effect while `cfg_load` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all delays count its rising edges |
| rst_n | input | 1 | Active-low asynchronous reset |
| sig_in | input | 1 | Logic level to be delayed, sampled every clock |
| cfg_value | input | 8 | New delay setting (steps) |
| cfg_load | input | 1 | Strobe: applies `cfg_value` at this edge |
| sig_out | output | 1 | Delayed copy of `sig_in` |
| settled | output | 1 | High when no setting change is still settling |
| overrun | output | 1 | Sticky: a transition displaced a pending one |

## Verification
A fault in the pending slot's countdown shows on `sig_out` as a transition that is early or late by a fixed number of cycles. A fault in its stored level shows as an inverted or missing transition. Either error appears at the very first release after the fault. A stale or mis-latched active setting shows up one full delay after the next sampled transition. A wrong settle counter shows at the edge where `settled` should rise. The bench compares all three outputs against a behavioural model on every clock, so a fault is reported in the cycle it first reaches a port.

// File: rtl/edly_pkg.sv
package edly_pkg;

  // Number of bits needed to hold values 0..maxv
  function automatic int bits_for(input int maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

  // One sampled input event
  typedef struct packed {
    logic hit;    // a transition was sampled this cycle
    logic level;  // the new level after the transition
  } edge_ev_t;

endpackage

// File: rtl/edly_sampler.sv
module edly_sampler
  import edly_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sig_in,
  output edge_ev_t ev_o
);

  logic level_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_ref <= 1'b0;
    else        level_ref <= sig_in;
  end

  always_comb begin
    ev_o.hit   = (sig_in != level_ref);
    ev_o.level = sig_in;
  end

endmodule

// File: rtl/edly_cfg.sv
module edly_cfg #(
  parameter int VAL_W         = 8,
  parameter int BASE_CYCLES   = 4,
  parameter int STEP_CYCLES   = 2,
  parameter int SETTLE_CYCLES = 20,
  parameter int DLY_W         = 10,
  parameter int SET_W         = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [VAL_W-1:0] value_i,
  output logic [DLY_W-1:0] delay_o,
  output logic             settled_o
);

  logic [VAL_W-1:0] active_q;
  logic [SET_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
      remain_q <= '0;
    end else if (load_i) begin
      active_q <= value_i;
      remain_q <= SET_W'(SETTLE_CYCLES);
    end else if (remain_q != '0) begin
      remain_q <= remain_q - SET_W'(1);
    end
  end

  // Unit step needs only an adder; other steps need a constant multiply
  generate
    if (STEP_CYCLES == 1) begin : g_unit_step
      assign delay_o = DLY_W'(BASE_CYCLES) + DLY_W'(active_q);
    end else begin : g_scaled_step
      assign delay_o = DLY_W'(BASE_CYCLES) + DLY_W'(active_q) * DLY_W'(STEP_CYCLES);
    end
  endgenerate

  assign settled_o = (remain_q == '0);

  // R6
  load_unsettles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !settled_o);

  // R7
  settle_rise_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settled_o) |-> !$past(load_i));

  // R10
  value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(delay_o));

endmodule

// File: rtl/edly_tracker.sv
module edly_tracker
  import edly_pkg::*;
#(
  parameter int DLY_W     = 10,
  parameter int MAX_DELAY = 514
) (
  input  logic             clk,
  input  logic             rst_n,
  input  edge_ev_t         ev_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             out_o,
  output logic             ovr_o
);

  logic             pend_q;
  logic             plevel_q;
  logic [DLY_W-1:0] count_q;
  logic             release_now;

  assign release_now = pend_q && (count_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      plevel_q <= 1'b0;
      count_q  <= '0;
      out_o    <= 1'b0;
      ovr_o    <= 1'b0;
    end else begin
      if (release_now) out_o <= plevel_q;
      if (ev_i.hit) begin
        pend_q   <= 1'b1;
        plevel_q <= ev_i.level;
        count_q  <= delay_i - DLY_W'(1);
        if (pend_q && !release_now) ovr_o <= 1'b1;
      end else if (release_now) begin
        pend_q <= 1'b0;
      end else if (pend_q) begin
        count_q <= count_q - DLY_W'(1);
      end
    end
  end

  // R2
  out_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_o != $past(out_o)) |-> $past(pend_q));

  // R2
  edge_arms_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i.hit |=> pend_q);

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_o |=> ovr_o);

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (count_q <= DLY_W'(MAX_DELAY - 1)));

endmodule

// File: rtl/edge_delay_core.sv
module edge_delay_core
  import edly_pkg::*;
#(
  parameter int VAL_W         = 8,
  parameter int BASE_CYCLES   = 4,
  parameter int STEP_CYCLES   = 2,
  parameter int SETTLE_CYCLES = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_in,
  input  logic [VAL_W-1:0] cfg_value,
  input  logic             cfg_load,
  output logic             sig_out,
  output logic             settled,
  output logic             overrun
);

  localparam int MAX_DELAY = BASE_CYCLES + ((1 << VAL_W) - 1) * STEP_CYCLES;
  localparam int DLY_W     = bits_for(MAX_DELAY);
  localparam int SET_W     = bits_for(SETTLE_CYCLES);

  generate
    if (BASE_CYCLES < 1 || STEP_CYCLES < 1 || SETTLE_CYCLES < 1) begin : g_bad_cfg
      $error("edge_delay_core: base, step and settle counts must be at least 1");
    end
  endgenerate

  edge_ev_t         ev;
  logic [DLY_W-1:0] delay_cur;

  edly_sampler u_sampler (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_in (sig_in),
    .ev_o   (ev)
  );

  edly_cfg #(
    .VAL_W         (VAL_W),
    .BASE_CYCLES   (BASE_CYCLES),
    .STEP_CYCLES   (STEP_CYCLES),
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .DLY_W         (DLY_W),
    .SET_W         (SET_W)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (cfg_load),
    .value_i   (cfg_value),
    .delay_o   (delay_cur),
    .settled_o (settled)
  );

  edly_tracker #(
    .DLY_W     (DLY_W),
    .MAX_DELAY (MAX_DELAY)
  ) u_tracker (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_i    (ev),
    .delay_i (delay_cur),
    .out_o   (sig_out),
    .ovr_o   (overrun)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!sig_out && settled && !overrun));

endmodule

// File: tb/edge_delay_core_bench.sv
`timescale 1ns/1ps
module edge_delay_core_bench;

  localparam int BASE   = 4;
  localparam int STEP   = 2;
  localparam int SETTLE = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sig_in = 1'b0;
  logic [7:0] cfg_value = 8'd0;
  logic       cfg_load = 1'b0;
  logic       sig_out, settled, overrun;

  edge_delay_core #(
    .VAL_W(8), .BASE_CYCLES(BASE), .STEP_CYCLES(STEP), .SETTLE_CYCLES(SETTLE)
  ) u_edge_delay_core (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .cfg_value(cfg_value),
    .cfg_load(cfg_load), .sig_out(sig_out), .settled(settled), .overrun(overrun)
  );

  always #2.5 clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  string phase  = "R1";

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  typedef struct { int due; logic lvl; } ev_t;
  ev_t  q[$];
  int   cyc = 0;
  int   m_val = 0;
  int   m_rem = 0;
  logic m_last = 1'b0;
  logic m_out = 1'b0;
  logic m_ovr = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      q.delete(); m_val = 0; m_rem = 0; m_last = 1'b0; m_out = 1'b0; m_ovr = 1'b0;
    end else begin
      if (q.size() > 0 && q[0].due == cyc) begin
        m_out = q[0].lvl;
        q.delete(0);
      end
      if (sig_in !== m_last) begin
        if (q.size() > 0) begin
          m_ovr = 1'b1;
          q.delete();
        end
        q.push_back('{cyc + BASE + m_val * STEP, sig_in});
        m_last = sig_in;
      end
      if (cfg_load) begin
        m_val = int'(cfg_value);
        m_rem = SETTLE;
      end else if (m_rem > 0) begin
        m_rem--;
      end
    end
    #2;
    chk(sig_out === m_out, phase, "sig_out vs model", int'(sig_out), int'(m_out));
    chk(settled === (m_rem == 0), phase, "settled vs model", int'(settled), int'(m_rem == 0));
    chk(overrun === m_ovr, phase, "overrun vs model", int'(overrun), int'(m_ovr));
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sig_in = 1'b0; cfg_load = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic load(input int v);
    @(negedge clk);
    cfg_value = 8'(v); cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic wait_settled();
    int n = 0;
    while (!settled && n < 1000) begin @(negedge clk); n++; end
  endtask

  // Drive a level, count negedges until sig_out follows; a change at edge k+D
  // is first seen on the (D+1)th negedge after the drive.
  task automatic measure(input logic lvl, input int exp_d, input string req);
    int n = 0;
    @(negedge clk);
    sig_in = lvl;
    do begin @(negedge clk); n++; end while (sig_out !== lvl && n < 2000);
    chk(n == exp_d + 1, req, "delay (negedges incl. sampling)", n, exp_d + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while in reset
    chk(sig_out === 1'b0, "R1", "sig_out in reset", int'(sig_out), 0);
    chk(settled === 1'b1, "R1", "settled in reset", int'(settled), 1);
    chk(overrun === 1'b0, "R1", "overrun in reset", int'(overrun), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sig_out === 1'b0, "R1", "sig_out after reset", int'(sig_out), 0);

    // R3: zero setting gives the base delay; R4: both edges equal
    phase = "R3";
    measure(1'b1, BASE, "R3");
    phase = "R4";
    measure(1'b0, BASE, "R4");

    // R6: settle window length
    phase = "R6";
    begin
      int n = 0;
      @(negedge clk);
      cfg_value = 8'd5; cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
      while (!settled && n < 1000) begin n++; @(negedge clk); end
      chk(n == SETTLE, "R6", "cycles with settled low", n, SETTLE);
    end

    // R2: non-inverted copy with a mid setting
    phase = "R2";
    measure(1'b1, BASE + 5 * STEP, "R2");
    chk(sig_out === 1'b1, "R2", "level copied", int'(sig_out), 1);
    measure(1'b0, BASE + 5 * STEP, "R4");

    // R3: largest setting
    phase = "R3";
    load(255); wait_settled();
    measure(1'b1, BASE + 255 * STEP, "R3");
    measure(1'b0, BASE + 255 * STEP, "R3");

    // R10: value change without strobe is ignored
    phase = "R10";
    load(3); wait_settled();
    @(negedge clk); cfg_value = 8'd200;
    measure(1'b1, BASE + 3 * STEP, "R10");
    chk(settled === 1'b1, "R10", "settled untouched", int'(settled), 1);
    measure(1'b0, BASE + 3 * STEP, "R10");

    // R5: load and edge at the same edge -> old delay; later edge -> new delay
    phase = "R5";
    begin
      int n = 0;
      @(negedge clk);
      cfg_value = 8'd10; cfg_load = 1'b1; sig_in = 1'b1;
      @(negedge clk); cfg_load = 1'b0; n = 1;
      while (sig_out !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
      chk(n == BASE + 3 * STEP + 1, "R5", "same-edge load uses old delay", n, BASE + 3 * STEP + 1);
    end
    measure(1'b0, BASE + 10 * STEP, "R5");

    // R7: reload mid-window restarts it
    phase = "R7";
    begin
      int n = 0;
      load(7);
      repeat (8) @(negedge clk);
      @(negedge clk); cfg_value = 8'd2; cfg_load = 1'b1;
      @(negedge clk); cfg_load = 1'b0;
      while (!settled && n < 1000) begin n++; @(negedge clk); end
      chk(n == SETTLE, "R7", "window after reload", n, SETTLE);
    end

    // R9: edge sampled exactly at release time, no overrun
    phase = "R9";
    do_reset();
    @(negedge clk); sig_in = 1'b1;
    repeat (BASE) @(negedge clk);
    sig_in = 1'b0;
    begin
      int highs = 0;
      for (int i = 0; i < 3 * BASE; i++) begin
        @(negedge clk);
        if (sig_out === 1'b1) highs++;
      end
      chk(highs == BASE, "R9", "output high cycles", highs, BASE);
    end
    chk(overrun === 1'b0, "R9", "overrun", int'(overrun), 0);

    // R8: short glitch is displaced and flagged
    phase = "R8";
    load(5); wait_settled();
    @(negedge clk); sig_in = 1'b1;
    repeat (2) @(negedge clk);
    sig_in = 1'b0;
    begin
      int highs = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (sig_out === 1'b1) highs++;
      end
      chk(highs == 0, "R8", "glitch reached output", highs, 0);
    end
    chk(overrun === 1'b1, "R8", "overrun set", int'(overrun), 1);
    measure(1'b1, BASE + 5 * STEP, "R8");
    chk(overrun === 1'b1, "R8", "overrun sticky", int'(overrun), 1);

    // R1: reset clears the sticky flag and the output
    phase = "R1";
    do_reset();
    @(negedge clk);
    chk(overrun === 1'b0, "R1", "overrun cleared by reset", int'(overrun), 0);
    chk(sig_out === 1'b0, "R1", "sig_out cleared by reset", int'(sig_out), 0);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog: actual %0d cycles expected fewer", 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule